// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

The block is the master side of a serial audio link. From its function clock it produces a bit clock, a word-select line and one serial data line. The samples come from a small transmit queue in which each entry holds a left and a right channel word. The block is configured through static inputs. These set the framing shape, the sample width, the frame length, where the channel data sits inside the frame, the bit-clock divider, the output polarities, mono or stereo operation, the half of the entry that carries the right channel, and what happens when the queue runs dry.

One framing engine produces four word-select shapes. The first is the classic two-channel shape, in which word select is low for the left half of the frame and the data trails by one bit clock. The other three are DSP-style shapes: a half-frame level, a single bit-clock pulse, and a pulse one data slot wide. The queue raises a level interrupt when its occupancy falls to the watermark or below. A sticky error flag records every frame that found the queue empty.

Software typically programs the configuration while the block is disabled, preloads a few entries, and then enables it. After that it keeps the queue topped up from the level interrupt.

Top module: `audio_frame_tx`

## Requirements
- R1: After reset, or while `cfg_enable` is low, `sck` equals `cfg_sck_inv`, `ws` equals `cfg_ws_inv`, `sd` is 0, `err_underrun` is 0 after reset, and `wr_full` is 0 with an empty queue.
- R2: While enabled, the uninverted bit clock is low for `cfg_div_m1`+1 function-clock cycles and then high for the same number, so its period is 2·(`cfg_div_m1`+1). `ws` and `sd` change only while the uninverted bit clock is low, so a receiver samples them on its rising edge.
- R3: With `cfg_mode` = 0 (classic), word select is 0 for frame bits below F/2 and 1 from F/2 on, where F = `cfg_frame_len_m1`+1. The data bit index s is the frame bit index delayed by one (frame bit 0 maps to s = F−1). The left word occupies s = P .. P+D−1 and the right word occupies s = F/2+P .. F/2+P+D−1, where P = `cfg_position` and D = `cfg_data_len_m1`+1.
- R4: With `cfg_mode` 1, 2 or 3 (DSP shapes), word select is high for frame bits below F/2 (mode 1), for frame bit 0 only (mode 2), or for frame bits below D (mode 3). Here s equals the frame bit index, the left word occupies s = P .. P+D−1 and the right word follows it directly at s = P+D .. P+2D−1.
- R5: Each word sends bits D−1 down to 0 of its channel, MSB first. `sd` is 0 in every bit outside the active slots.
- R6: With `cfg_mono` set, the right slot carries 0 and each frame still consumes one queue entry, of which only the left word is sent.
- R7: An entry written on `wr_data` carries the left word in bits [31:0] and the right word in bits [63:32] when `cfg_right_low` is 0. When `cfg_right_low` is 1 the two halves are swapped.
- R8: `cfg_sck_inv` and `cfg_ws_inv` invert the `sck` and `ws` outputs.
- R9: The queue holds 8 entries. `wr_full` is 1 when it holds 8, and a write is ignored while it is full. One entry is taken per frame, in the bit where s = 0.
- R10: `irq_level` is 1 exactly while the queue holds no more than `cfg_watermark` entries.
- R11: When a frame finds the queue empty, it sends zeros if `cfg_zero_fill` is 1 and repeats the previous entry if it is 0. In both cases `err_underrun` is set, and it stays set until a cycle with `err_clr` high (a new underrun in the same cycle wins).
- R12: Clearing `cfg_enable` returns the outputs to the idle state of R1. The next enable starts again at frame bit 0, with the held words cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Run the transmitter |
| cfg_mode | input | 2 | Framing shape: 0 classic, 1 DSP half-frame, 2 DSP one-bit pulse, 3 DSP one-slot pulse |
| cfg_data_len_m1 | input | 5 | Sample width minus one (3..31) |
| cfg_frame_len_m1 | input | 9 | Frame length in bit clocks minus one (3..511) |
| cfg_position | input | 9 | Bit offset of the left word inside the frame |
| cfg_div_m1 | input | 12 | Bit-clock half-period in function clocks minus one |
| cfg_sck_inv | input | 1 | Invert the bit clock output |
| cfg_ws_inv | input | 1 | Invert the word-select output |
| cfg_mono | input | 1 | Send the left slot only |
| cfg_right_low | input | 1 | Right word in the low half of an entry |
| cfg_zero_fill | input | 1 | Send zeros on underrun instead of repeating |
| cfg_watermark | input | 4 | Level-interrupt threshold |
| wr_valid | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 64 | Stereo queue entry |
| err_clr | input | 1 | Clear the underrun flag |
| wr_full | output | 1 | Queue holds 8 entries |
| irq_level | output | 1 | Occupancy at or below the watermark |
| err_underrun | output | 1 | Sticky underrun flag |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |

## Verification
The assertions assume that the polarity controls change only while the block is disabled, because the data-stability property is written against the inverted clock output. They also assume that the frame geometry always fits, so that the slots end inside the frame: P+2D ≤ F in DSP shapes, and P+D ≤ F/2 with an even F in classic shape. The bench changes every configuration input only while `cfg_enable` is low. It picks frame lengths, widths and positions that satisfy these fits, including the tightest ones (D equal to half the frame, and a 4-bit sample in an 8-bit frame). It applies `err_clr` only between runs.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int ATX_SAMPLE_W   = 32;
  localparam int ATX_FIFO_DEPTH = 8;
  localparam int ATX_DIV_W      = 12;
  localparam int ATX_FRAME_W    = 9;

  typedef enum logic [1:0] {
    FMT_CLASSIC   = 2'd0,
    FMT_DSP_HALF  = 2'd1,
    FMT_DSP_PULSE = 2'd2,
    FMT_DSP_SLOT  = 2'd3
  } atx_fmt_e;
endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_n;
  logic             do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = count;
    if (do_wr) wp_n = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_n = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_n = count + 1'b1;
      2'b01:   cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      count <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/atx_bitclk.sv
module atx_bitclk #(
  parameter int DIV_W   = 12,
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [DIV_W-1:0]   div_m1,
  input  logic [FRAME_W-1:0] flen_m1,
  output logic               sck_raw,
  output logic               bit_start,
  output logic [FRAME_W-1:0] bit_idx
);
  logic               run_q, run_n;
  logic [DIV_W-1:0]   hc_q, hc_n;
  logic               ph_q, ph_n;
  logic [FRAME_W-1:0] bc_q, bc_n;

  always_comb begin
    run_n     = run_q;
    hc_n      = hc_q;
    ph_n      = ph_q;
    bc_n      = bc_q;
    bit_start = 1'b0;
    if (!en) begin
      run_n = 1'b0;
      hc_n  = '0;
      ph_n  = 1'b0;
      bc_n  = '0;
    end else if (!run_q) begin
      run_n     = 1'b1;
      bit_start = 1'b1;
    end else if (hc_q == div_m1) begin
      hc_n = '0;
      ph_n = ~ph_q;
      if (ph_q) begin
        bit_start = 1'b1;
        bc_n      = (bc_q == flen_m1) ? '0 : bc_q + 1'b1;
      end
    end else begin
      hc_n = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      hc_q  <= '0;
      ph_q  <= 1'b0;
      bc_q  <= '0;
    end else begin
      run_q <= run_n;
      hc_q  <= hc_n;
      ph_q  <= ph_n;
      bc_q  <= bc_n;
    end
  end

  assign sck_raw = ph_q;
  assign bit_idx = bc_n;
endmodule

// File: rtl/atx_framer.sv
module atx_framer
  import atx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int FRAME_W  = 9,
  localparam int LEN_W   = $clog2(SAMPLE_W),
  localparam int PW      = FRAME_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [1:0]            mode,
  input  logic [LEN_W-1:0]      dlen_m1,
  input  logic [FRAME_W-1:0]    flen_m1,
  input  logic [FRAME_W-1:0]    pos,
  input  logic                  mono,
  input  logic                  right_low,
  input  logic                  zero_fill,
  input  logic                  bit_start,
  input  logic [FRAME_W-1:0]    bit_idx,
  input  logic [2*SAMPLE_W-1:0] head,
  input  logic                  empty,
  output logic                  pop,
  output logic                  underrun,
  output logic                  ws_raw,
  output logic                  sd
);
  atx_fmt_e fmt;
  logic [PW-1:0] flen, half, dlen, b, s, pos_e, l_end, r_beg, r_end, kl, kr;
  logic [LEN_W-1:0] il, ir;
  logic [SAMPLE_W-1:0] lo_w, hi_w, head_l, head_r, hold_l, hold_r, new_l, new_r;
  logic fetch, in_l, in_r, ws_n, sd_n;

  assign fmt   = atx_fmt_e'(mode);
  assign flen  = PW'(flen_m1) + 1'b1;
  assign half  = flen >> 1;
  assign dlen  = PW'(dlen_m1) + 1'b1;
  assign b     = PW'(bit_idx);
  assign pos_e = PW'(pos);

  // classic framing trails the word-select edge by one bit
  always_comb begin
    if (fmt == FMT_CLASSIC) s = (b == '0) ? flen - 1'b1 : b - 1'b1;
    else                    s = b;
  end

  assign fetch    = bit_start && (s == '0);
  assign pop      = fetch && !empty;
  assign underrun = fetch && empty;

  assign lo_w   = head[SAMPLE_W-1:0];
  assign hi_w   = head[2*SAMPLE_W-1:SAMPLE_W];
  assign head_l = right_low ? hi_w : lo_w;
  assign head_r = right_low ? lo_w : hi_w;

  always_comb begin
    new_l = hold_l;
    new_r = hold_r;
    if (fetch) begin
      if (!empty) begin
        new_l = head_l;
        new_r = head_r;
      end else if (zero_fill) begin
        new_l = '0;
        new_r = '0;
      end
    end
  end

  assign l_end = pos_e + dlen;
  assign r_beg = (fmt == FMT_CLASSIC) ? half + pos_e : l_end;
  assign r_end = r_beg + dlen;
  assign in_l  = (s >= pos_e) && (s < l_end);
  assign in_r  = !mono && (s >= r_beg) && (s < r_end);
  assign kl    = s - pos_e;
  assign kr    = s - r_beg;
  assign il    = LEN_W'(dlen - 1'b1 - kl);
  assign ir    = LEN_W'(dlen - 1'b1 - kr);

  always_comb begin
    if (in_l)      sd_n = new_l[il];
    else if (in_r) sd_n = new_r[ir];
    else           sd_n = 1'b0;
  end

  always_comb begin
    unique case (fmt)
      FMT_CLASSIC:   ws_n = (b >= half);
      FMT_DSP_HALF:  ws_n = (b < half);
      FMT_DSP_PULSE: ws_n = (b == '0);
      FMT_DSP_SLOT:  ws_n = (b < dlen);
      default:       ws_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_raw <= 1'b0;
      sd     <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (!en) begin
      ws_raw <= 1'b0;
      sd     <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (bit_start) begin
      ws_raw <= ws_n;
      sd     <= sd_n;
      hold_l <= new_l;
      hold_r <= new_r;
    end
  end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import atx_pkg::*;
#(
  parameter int SAMPLE_W   = ATX_SAMPLE_W,
  parameter int FIFO_DEPTH = ATX_FIFO_DEPTH,
  parameter int DIV_W      = ATX_DIV_W,
  parameter int FRAME_W    = ATX_FRAME_W,
  localparam int LEN_W     = $clog2(SAMPLE_W),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int ENTRY_W   = 2 * SAMPLE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [1:0]         cfg_mode,
  input  logic [LEN_W-1:0]   cfg_data_len_m1,
  input  logic [FRAME_W-1:0] cfg_frame_len_m1,
  input  logic [FRAME_W-1:0] cfg_position,
  input  logic [DIV_W-1:0]   cfg_div_m1,
  input  logic               cfg_sck_inv,
  input  logic               cfg_ws_inv,
  input  logic               cfg_mono,
  input  logic               cfg_right_low,
  input  logic               cfg_zero_fill,
  input  logic [CNT_W-1:0]   cfg_watermark,
  input  logic               wr_valid,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               err_clr,
  output logic               wr_full,
  output logic               irq_level,
  output logic               err_underrun,
  output logic               sck,
  output logic               ws,
  output logic               sd
);
  logic [ENTRY_W-1:0] fifo_head;
  logic [CNT_W-1:0]   fifo_cnt;
  logic               fifo_empty, fifo_pop, underrun_evt;
  logic               sck_raw, bit_start, ws_raw;
  logic [FRAME_W-1:0] bit_idx;
  logic               err_n;

  atx_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .rd_en   (fifo_pop),
    .head    (fifo_head),
    .empty   (fifo_empty),
    .full    (wr_full),
    .count   (fifo_cnt)
  );

  atx_bitclk #(.DIV_W(DIV_W), .FRAME_W(FRAME_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_enable),
    .div_m1    (cfg_div_m1),
    .flen_m1   (cfg_frame_len_m1),
    .sck_raw   (sck_raw),
    .bit_start (bit_start),
    .bit_idx   (bit_idx)
  );

  atx_framer #(.SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_enable),
    .mode      (cfg_mode),
    .dlen_m1   (cfg_data_len_m1),
    .flen_m1   (cfg_frame_len_m1),
    .pos       (cfg_position),
    .mono      (cfg_mono),
    .right_low (cfg_right_low),
    .zero_fill (cfg_zero_fill),
    .bit_start (bit_start),
    .bit_idx   (bit_idx),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .pop       (fifo_pop),
    .underrun  (underrun_evt),
    .ws_raw    (ws_raw),
    .sd        (sd)
  );

  always_comb begin
    err_n = err_underrun;
    if (err_clr)      err_n = 1'b0;
    if (underrun_evt) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_underrun <= 1'b0;
    else        err_underrun <= err_n;
  end

  assign irq_level = (fifo_cnt <= cfg_watermark);
  assign sck       = sck_raw ^ cfg_sck_inv;
  assign ws        = ws_raw ^ cfg_ws_inv;
endmodule

// File: rtl/atx_checks.sv
module atx_checks (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_sck_inv,
  input logic cfg_ws_inv,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic err_clr,
  input logic err_underrun,
  input logic underrun_evt
);
  // R2: serial data moves only while the bit clock is in its low phase
  assert_sd_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> ((sck ^ cfg_sck_inv) == 1'b0));

  // R2: word select moves only while the bit clock is in its low phase
  assert_ws_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws ^ cfg_ws_inv) |-> ((sck ^ cfg_sck_inv) == 1'b0));

  // R11: flag holds until cleared
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_underrun && !err_clr) |=> err_underrun);

  // R11: a clear without a new underrun drops the flag
  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !underrun_evt) |=> !err_underrun);

  // R12: disabling returns the lines to idle
  assert_idle_lines_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (sck == cfg_sck_inv) && (sd == 1'b0) && (ws == cfg_ws_inv));
endmodule

bind audio_frame_tx atx_checks u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .cfg_sck_inv  (cfg_sck_inv),
  .cfg_ws_inv   (cfg_ws_inv),
  .sck          (sck),
  .ws           (ws),
  .sd           (sd),
  .err_clr      (err_clr),
  .err_underrun (err_underrun),
  .underrun_evt (underrun_evt)
);

// File: tb/sim_audio_frame_tx.sv
module sim_audio_frame_tx;
  logic        clk, rst_n;
  logic        cfg_enable;
  logic [1:0]  cfg_mode;
  logic [4:0]  cfg_data_len_m1;
  logic [8:0]  cfg_frame_len_m1, cfg_position;
  logic [11:0] cfg_div_m1;
  logic        cfg_sck_inv, cfg_ws_inv, cfg_mono, cfg_right_low, cfg_zero_fill;
  logic [3:0]  cfg_watermark;
  logic        wr_valid;
  logic [63:0] wr_data;
  logic        err_clr;
  logic        wr_full, irq_level, err_underrun, sck, ws, sd;

  audio_frame_tx u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string cur_req;
  logic [1:0] exp_q[$];
  bit mon_on = 0;
  logic [31:0] smp_l[16], smp_r[16];
  int n_acc;
  bit exp_err;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // monitor: pops one expected {ws,sd} per rising bit-clock edge
  initial begin
    bit prev_eff, eff, have_last;
    int cyc, last_rise;
    logic [1:0] e;
    prev_eff = 0; have_last = 0; cyc = 0; last_rise = 0;
    forever begin
      @(negedge clk);
      cyc++;
      eff = sck ^ cfg_sck_inv;
      if (mon_on && !prev_eff && eff) begin
        if (have_last)
          check("R2 period", 64'(cyc - last_rise), 64'(2 * (int'(cfg_div_m1) + 1)));
        have_last = 1;
        last_rise = cyc;
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check(cur_req, {62'd0, ws, sd}, {62'd0, e});
          if (exp_q.size() == 0) begin
            cfg_enable = 1'b0;
            mon_on = 0;
          end
        end
      end
      if (!mon_on) have_last = 0;
      prev_eff = eff;
    end
  end

  task automatic set_cfg(input int md, input int dm1, input int fm1, input int ps,
                         input int dv, input bit mo, input bit rl, input bit zf,
                         input bit si, input bit wi, input int wm);
    @(negedge clk);
    cfg_mode = 2'(md); cfg_data_len_m1 = 5'(dm1); cfg_frame_len_m1 = 9'(fm1);
    cfg_position = 9'(ps); cfg_div_m1 = 12'(dv); cfg_mono = mo; cfg_right_low = rl;
    cfg_zero_fill = zf; cfg_sck_inv = si; cfg_ws_inv = wi; cfg_watermark = 4'(wm);
  endtask

  // driver: push entries, the queue model keeps at most 8
  task automatic push_entries(input int n, input int seed);
    n_acc = 0;
    for (int i = 0; i < n; i++) begin
      smp_l[i] = (32'h9E37_79B9 * 32'(i + seed + 1)) ^ 32'h8000_0001;
      smp_r[i] = 32'h7F4A_7C15 ^ (32'(i + seed) * 32'h0101_0103);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = cfg_right_low ? {smp_l[i], smp_r[i]} : {smp_r[i], smp_l[i]};
      if (n_acc < 8) n_acc++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // expected bit stream from the framing rules
  task automatic gen_stream(input int frames);
    int F, H, D, P, md, s, b, idx, rb;
    logic [31:0] hl, hr;
    bit w, d;
    F = int'(cfg_frame_len_m1) + 1; H = F / 2; D = int'(cfg_data_len_m1) + 1;
    P = int'(cfg_position); md = int'(cfg_mode);
    hl = 0; hr = 0; idx = 0; exp_err = 0;
    for (int t = 0; t < frames * F; t++) begin
      b = t % F;
      s = (md == 0) ? ((b == 0) ? F - 1 : b - 1) : b;
      if (s == 0) begin
        if (idx < n_acc) begin hl = smp_l[idx]; hr = smp_r[idx]; idx++; end
        else begin exp_err = 1; if (cfg_zero_fill) begin hl = 0; hr = 0; end end
      end
      rb = (md == 0) ? H + P : P + D;
      d = 0;
      if (s >= P && s < P + D) d = hl[D - 1 - (s - P)];
      else if (!cfg_mono && s >= rb && s < rb + D) d = hr[D - 1 - (s - rb)];
      case (md)
        0: w = (b >= H);
        1: w = (b < H);
        2: w = (b == 0);
        default: w = (b < D);
      endcase
      exp_q.push_back({w ^ cfg_ws_inv, d});
    end
  endtask

  task automatic run(input string req, input int frames);
    cur_req = req;
    gen_stream(frames);
    @(negedge clk);
    mon_on = 1;
    cfg_enable = 1'b1;
    while (cfg_enable) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R12 idle sck", {63'd0, sck}, {63'd0, cfg_sck_inv});
    check("R12 idle ws", {63'd0, ws}, {63'd0, cfg_ws_inv});
    check("R12 idle sd", {63'd0, sd}, 64'd0);
    check("R11 flag after run", {63'd0, err_underrun}, {63'd0, exp_err});
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    check("R11 flag cleared", {63'd0, err_underrun}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; wr_valid = 1'b0; wr_data = '0; err_clr = 1'b0;
    cfg_mode = 2'd0; cfg_data_len_m1 = 5'd15; cfg_frame_len_m1 = 9'd31; cfg_position = '0;
    cfg_div_m1 = '0; cfg_sck_inv = 0; cfg_ws_inv = 0; cfg_mono = 0; cfg_right_low = 0;
    cfg_zero_fill = 1; cfg_watermark = 4'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset sck", {63'd0, sck}, 64'd0);
    check("R1 reset ws", {63'd0, ws}, 64'd0);
    check("R1 reset sd", {63'd0, sd}, 64'd0);
    check("R1 reset err", {63'd0, err_underrun}, 64'd0);
    check("R1 reset full", {63'd0, wr_full}, 64'd0);
    check("R10 empty irq", {63'd0, irq_level}, 64'd1);

    // R3 R5: classic, 16-bit in 32-bit frame
    set_cfg(0, 15, 31, 0, 0, 0, 0, 1, 0, 0, 4);
    push_entries(3, 0);
    check("R10 three below mark", {63'd0, irq_level}, 64'd1);
    run("R3 classic stream", 3);

    // R7 R3: right in low half, 24-bit in 64-bit frame, offset 2
    set_cfg(0, 23, 63, 2, 1, 0, 1, 1, 0, 0, 3);
    push_entries(4, 5);
    check("R10 four above mark", {63'd0, irq_level}, 64'd0);
    run("R7 swapped halves", 4);

    // R4: half-frame DSP shape
    set_cfg(1, 11, 39, 3, 2, 0, 0, 1, 0, 0, 4);
    push_entries(3, 9);
    run("R4 dsp half", 3);

    // R4 R6: one-bit pulse, mono
    set_cfg(2, 7, 19, 1, 0, 1, 0, 1, 0, 0, 4);
    push_entries(3, 13);
    run("R6 mono pulse", 3);

    // R4 R8: one-slot pulse with both inversions
    set_cfg(3, 19, 47, 0, 0, 0, 0, 1, 1, 1, 4);
    push_entries(2, 17);
    check("R8 idle inverted sck", {63'd0, sck}, 64'd1);
    check("R8 idle inverted ws", {63'd0, ws}, 64'd1);
    run("R8 dsp slot inverted", 2);

    // R9 R11: overfill, then drain past the end with zero fill
    set_cfg(0, 3, 7, 0, 0, 0, 0, 1, 0, 0, 4);
    push_entries(9, 21);
    check("R9 full flag", {63'd0, wr_full}, 64'd1);
    check("R10 full above mark", {63'd0, irq_level}, 64'd0);
    run("R9 R11 zero fill", 10);
    check("R9 drained", {63'd0, wr_full}, 64'd0);

    // R11: stale repeat, full 32-bit word filling each half
    set_cfg(0, 31, 63, 0, 3, 0, 0, 0, 0, 0, 0);
    push_entries(1, 33);
    check("R10 one above zero mark", {63'd0, irq_level}, 64'd0);
    run("R11 stale repeat", 3);
    check("R10 empty at zero mark", {63'd0, irq_level}, 64'd1);

    finish_run();
  end
endmodule